// File: doc/BRIEF.md
# Rebound Sorting Array

This block sorts a burst of fixed-width records in a linear chain of compare-and-steer cells. Each cell keeps one resident record and has one record-wide register that carries a record further down. Records enter at the head cell. At each cell the arriving record is compared with the resident one. The record that must leave earlier stays in the cell, and the other moves one cell down on the next clock. After the end-of-burst marker, the chain settles for a fixed number of cycles. It then reverses: every resident record moves one cell up per clock, and the sorted sequence leaves from the head cell, one record per cycle.

A new record may be offered on every clock while the burst loads. Two mode inputs choose the key interpretation (unsigned or two's complement) and the output order (smallest first or largest first). The modes are taken from the first record of a burst and hold until the burst has drained. Ports at the tail let a second identical array take the records that fall off the bottom, hand its sorted stream back up, and agree on a common drain start. A chained pair therefore sorts bursts twice as long.

Top module: `rebound_sorter`

## Requirements
- R1: A synchronous active-high reset empties every cell, returns the block to loading, and holds `out_valid` and `casc_dn_valid` low.
- R2: With `mode_desc`=0 and `mode_signed`=0, the records leave in non-decreasing unsigned order.
- R3: With `mode_desc`=1, the records leave in non-increasing order under the selected key interpretation.
- R4: With `mode_signed`=1, the key is a two's-complement number whose sign is bit REC_W-1, so negative keys precede positive ones in ascending order.
- R5: If `in_last` is sampled at clock edge E and no cascade is attached, the first sorted record appears after edge E+DEPTH. `out_valid` then stays high for exactly as many consecutive cycles as records were accepted, and each record appears exactly once.
- R6: A record is accepted on every cycle that `in_valid` is high while loading, whether it arrives back-to-back or with idle cycles in between.
- R7: Bursts of zero or one record and bursts smaller than the capacity sort and drain correctly.
- R8: The values of `mode_signed` and `mode_desc` at the first accepted record govern the whole burst. Later changes have no effect until the burst has drained.
- R9: `in_valid`, `in_data` and `in_last` are ignored while the block is settling or draining.
- R10: Without a cascade, a burst longer than DEPTH yields only the DEPTH records that sort first. The rest are discarded.
- R11: With `casc_present`=1 and a second array attached at the tail, up to 2*DEPTH records are sorted. The first record appears after edge E+2*DEPTH.
- R12: An `in_last` pulse with `in_valid` low ends the burst without adding a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Record present on `in_data` |
| in_data | input | REC_W | Incoming record (whole record is the key) |
| in_last | input | 1 | End-of-burst marker |
| mode_signed | input | 1 | 1: two's-complement keys, 0: unsigned |
| mode_desc | input | 1 | 1: largest first, 0: smallest first |
| out_valid | output | 1 | Sorted record present on `out_data` |
| out_data | output | REC_W | Sorted record |
| casc_present | input | 1 | A second array is attached at the tail |
| casc_dn_valid | output | 1 | Record passed down to the next array |
| casc_dn_data | output | REC_W | Record passed down |
| casc_dn_last | output | 1 | End-of-burst marker passed down |
| casc_mode_signed | output | 1 | Burst key mode for the next array |
| casc_mode_desc | output | 1 | Burst order mode for the next array |
| casc_up_valid | input | 1 | Next array's sorted output valid |
| casc_up_data | input | REC_W | Next array's sorted output record |
| casc_start_in | input | 1 | Next array is ready to start draining this cycle |
| casc_start_out | output | 1 | This array is ready to start draining this cycle |

## Verification
In a one-record burst, mode capture and the end of the burst happen in the same cycle. That record must be sorted under the modes present on that edge, and it must drain after exactly DEPTH cycles. In a chained pair, the head array shifts its tail cell upward in the same cycle that the second array presents its own head record. Bursts that fill both arrays check this hand-off, because any slip would drop or duplicate a record at the junction. A behavioural queue model in the bench predicts `out_valid` and `out_data` for every cycle, including the one idle drain cycle. It flags any record that is missing, repeated or out of place. Junk records and end markers are driven throughout every settle and drain phase, to confirm that they leave no trace in the output.

// File: rtl/rebound_sort_pkg.sv
package rebound_sort_pkg;

    localparam int unsigned KEY_W = 64;

    typedef enum logic [1:0] {
        PH_LOAD   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_DRAIN  = 2'd2
    } phase_e;

    typedef struct packed {
        logic signed_keys;
        logic descending;
    } sort_mode_t;

    // True when record a must leave strictly before record b.
    function automatic logic goes_first(
        input logic [KEY_W-1:0] a,
        input logic [KEY_W-1:0] b,
        input logic [KEY_W-1:0] sign_mask,
        input sort_mode_t       mode
    );
        logic [KEY_W-1:0] ka;
        logic [KEY_W-1:0] kb;
        ka = mode.signed_keys ? (a ^ sign_mask) : a;
        kb = mode.signed_keys ? (b ^ sign_mask) : b;
        return mode.descending ? (ka > kb) : (ka < kb);
    endfunction

endpackage

// File: rtl/rebound_cell.sv
module rebound_cell
    import rebound_sort_pkg::*;
#(
    parameter int unsigned REC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  sort_mode_t       mode,
    input  logic             dn_valid,
    input  logic [REC_W-1:0] dn_data,
    input  logic             dn_last,
    input  logic             rise_valid,
    input  logic [REC_W-1:0] rise_data,
    output logic             hold_valid,
    output logic [REC_W-1:0] hold_data,
    output logic             pass_valid,
    output logic [REC_W-1:0] pass_data,
    output logic             pass_last
);

    localparam logic [KEY_W-1:0] SIGN_MASK = KEY_W'(1) << (REC_W - 1);

    logic take_new;

    // An empty slot always loses; ties keep the resident record.
    always_comb begin
        take_new = dn_valid &&
                   (!hold_valid ||
                    goes_first(KEY_W'(dn_data), KEY_W'(hold_data), SIGN_MASK, mode));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            pass_valid <= 1'b0;
            pass_last  <= 1'b0;
        end else if (phase == PH_DRAIN) begin
            hold_valid <= rise_valid;
            hold_data  <= rise_data;
            pass_valid <= 1'b0;
            pass_last  <= 1'b0;
        end else if (take_new) begin
            hold_valid <= 1'b1;
            hold_data  <= dn_data;
            pass_valid <= hold_valid;
            pass_data  <= hold_data;
            pass_last  <= dn_last;
        end else begin
            pass_valid <= dn_valid;
            pass_data  <= dn_data;
            pass_last  <= dn_last;
        end
    end

endmodule

// File: rtl/rebound_ctrl.sv
module rebound_ctrl
    import rebound_sort_pkg::*;
#(
    parameter int unsigned DEPTH = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_last,
    input  sort_mode_t mode_in,
    input  logic       head_valid,
    input  logic       casc_present,
    input  logic       casc_start_in,
    output phase_e     phase,
    output sort_mode_t mode_eff,
    output logic       start_drain
);

    localparam int unsigned CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DEPTH - 1);

    logic [CW-1:0] settle_cnt;
    logic          started;
    sort_mode_t    mode_q;

    always_comb begin
        start_drain = (phase == PH_SETTLE) && (settle_cnt == CNT_LAST) &&
                      (!casc_present || casc_start_in);
        mode_eff    = started ? mode_q : mode_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_LOAD;
            settle_cnt <= '0;
            started    <= 1'b0;
            mode_q     <= '0;
        end else begin
            case (phase)
                PH_LOAD: begin
                    if (in_valid && !started) begin
                        started <= 1'b1;
                        mode_q  <= mode_in;
                    end
                    if (in_last) begin
                        phase      <= PH_SETTLE;
                        settle_cnt <= '0;
                    end
                end
                PH_SETTLE: begin
                    if (start_drain) begin
                        phase <= PH_DRAIN;
                    end else if (settle_cnt != CNT_LAST) begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                PH_DRAIN: begin
                    if (!head_valid) begin
                        phase   <= PH_LOAD;
                        started <= 1'b0;
                    end
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

endmodule

// File: rtl/rebound_sorter.sv
module rebound_sorter
    import rebound_sort_pkg::*;
#(
    parameter int unsigned REC_W = 32,
    parameter int unsigned DEPTH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [REC_W-1:0] in_data,
    input  logic             in_last,
    input  logic             mode_signed,
    input  logic             mode_desc,
    output logic             out_valid,
    output logic [REC_W-1:0] out_data,
    input  logic             casc_present,
    output logic             casc_dn_valid,
    output logic [REC_W-1:0] casc_dn_data,
    output logic             casc_dn_last,
    output logic             casc_mode_signed,
    output logic             casc_mode_desc,
    input  logic             casc_up_valid,
    input  logic [REC_W-1:0] casc_up_data,
    input  logic             casc_start_in,
    output logic             casc_start_out
);

    phase_e     phase_q;
    sort_mode_t mode_in;
    sort_mode_t mode_eff;
    logic       start_drain;
    logic       loading;

    logic             hold_v [DEPTH];
    logic [REC_W-1:0] hold_d [DEPTH];
    logic             pass_v [DEPTH];
    logic [REC_W-1:0] pass_d [DEPTH];
    logic             pass_l [DEPTH];

    always_comb begin
        mode_in.signed_keys = mode_signed;
        mode_in.descending  = mode_desc;
        loading             = (phase_q == PH_LOAD);
    end

    rebound_ctrl #(
        .DEPTH(DEPTH)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_last      (in_last),
        .mode_in      (mode_in),
        .head_valid   (hold_v[0]),
        .casc_present (casc_present),
        .casc_start_in(casc_start_in),
        .phase        (phase_q),
        .mode_eff     (mode_eff),
        .start_drain  (start_drain)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic             dv;
        logic [REC_W-1:0] dd;
        logic             dl;
        logic             rv;
        logic [REC_W-1:0] rd;

        if (i == 0) begin : g_head
            assign dv = loading && in_valid;
            assign dd = in_data;
            assign dl = loading && in_last;
        end else begin : g_body
            assign dv = pass_v[i-1];
            assign dd = pass_d[i-1];
            assign dl = pass_l[i-1];
        end

        if (i == DEPTH - 1) begin : g_tail
            assign rv = casc_present && casc_up_valid;
            assign rd = casc_up_data;
        end else begin : g_inner
            assign rv = hold_v[i+1];
            assign rd = hold_d[i+1];
        end

        rebound_cell #(
            .REC_W(REC_W)
        ) u_cell (
            .clk       (clk),
            .rst       (rst),
            .phase     (phase_q),
            .mode      (mode_eff),
            .dn_valid  (dv),
            .dn_data   (dd),
            .dn_last   (dl),
            .rise_valid(rv),
            .rise_data (rd),
            .hold_valid(hold_v[i]),
            .hold_data (hold_d[i]),
            .pass_valid(pass_v[i]),
            .pass_data (pass_d[i]),
            .pass_last (pass_l[i])
        );
    end

    always_comb begin
        out_valid        = (phase_q == PH_DRAIN) && hold_v[0];
        out_data         = hold_d[0];
        casc_dn_valid    = casc_present && pass_v[DEPTH-1];
        casc_dn_data     = pass_d[DEPTH-1];
        casc_dn_last     = casc_present && pass_l[DEPTH-1];
        casc_mode_signed = mode_eff.signed_keys;
        casc_mode_desc   = mode_eff.descending;
        casc_start_out   = start_drain;
    end

endmodule

// File: rtl/rebound_sorter_chk.sv
module rebound_sorter_chk
    import rebound_sort_pkg::*;
#(
    parameter int unsigned REC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_last,
    input logic             out_valid,
    input logic [REC_W-1:0] out_data,
    input phase_e           phase,
    input sort_mode_t       mode_eff
);

    localparam logic [KEY_W-1:0] SIGN_MASK = KEY_W'(1) << (REC_W - 1);

    logic armed = 1'b0;
    always @(posedge clk) armed <= !rst;

    AST_ORDERED_STREAM: assert property (@(posedge clk) disable iff (rst || !armed)
        (out_valid && $past(out_valid)) |->
            !goes_first(KEY_W'(out_data), KEY_W'($past(out_data)), SIGN_MASK, mode_eff)); // R2

    AST_VALID_NO_GAP: assert property (@(posedge clk) disable iff (rst || !armed)
        $fell(out_valid) |=> !out_valid); // R5

    AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (rst || !armed)
        (phase == PH_DRAIN && !out_valid) |=> (phase == PH_LOAD)); // R5

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst || !armed)
        (phase == PH_DRAIN && $past(phase) == PH_DRAIN) |-> $stable(mode_eff)); // R8

    AST_LOAD_WAITS_LAST: assert property (@(posedge clk) disable iff (rst || !armed)
        (phase == PH_LOAD && !in_last) |=> (phase == PH_LOAD)); // R9

endmodule

bind rebound_sorter rebound_sorter_chk #(.REC_W(REC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_last  (in_last),
    .out_valid(out_valid),
    .out_data (out_data),
    .phase    (phase_q),
    .mode_eff (mode_eff)
);

// File: tb/rebound_sorter_bench.sv
`timescale 1ns/1ps
module rebound_sorter_bench;

    localparam int W = 32;
    localparam int D = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_last = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         m_signed = 1'b0;
    logic         m_desc = 1'b0;
    logic         casc_en = 1'b0;

    logic         out_valid;
    logic [W-1:0] out_data;
    logic         cd_valid, cd_last, cm_signed, cm_desc, near_start;
    logic [W-1:0] cd_data;
    logic         f_out_valid, f_cd_valid, f_cd_last, f_cm_signed, f_cm_desc, f_start;
    logic [W-1:0] f_out_data, f_cd_data;

    rebound_sorter #(.REC_W(W), .DEPTH(D)) u_rebound_sorter (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .mode_signed(m_signed), .mode_desc(m_desc),
        .out_valid(out_valid), .out_data(out_data),
        .casc_present(casc_en),
        .casc_dn_valid(cd_valid), .casc_dn_data(cd_data), .casc_dn_last(cd_last),
        .casc_mode_signed(cm_signed), .casc_mode_desc(cm_desc),
        .casc_up_valid(f_out_valid), .casc_up_data(f_out_data),
        .casc_start_in(f_start), .casc_start_out(near_start)
    );

    rebound_sorter #(.REC_W(W), .DEPTH(D)) u_far (
        .clk(clk), .rst(rst),
        .in_valid(cd_valid), .in_data(cd_data), .in_last(cd_last),
        .mode_signed(cm_signed), .mode_desc(cm_desc),
        .out_valid(f_out_valid), .out_data(f_out_data),
        .casc_present(1'b0),
        .casc_dn_valid(f_cd_valid), .casc_dn_data(f_cd_data), .casc_dn_last(f_cd_last),
        .casc_mode_signed(f_cm_signed), .casc_mode_desc(f_cm_desc),
        .casc_up_valid(1'b0), .casc_up_data('0),
        .casc_start_in(1'b0), .casc_start_out(f_start)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    chk_en = 1'b0;

    // Behavioural reference: phase, countdown, sorted queue.
    int           mphase = 0;
    int           mwait = 0;
    logic [W-1:0] mq[$];
    bit           mstarted = 1'b0;
    bit           msg = 1'b0;
    bit           mds = 1'b0;

    function automatic bit b_first(logic [W-1:0] a, logic [W-1:0] b);
        bit lt, gt;
        lt = msg ? ($signed(a) < $signed(b)) : (a < b);
        gt = msg ? ($signed(a) > $signed(b)) : (a > b);
        return mds ? gt : lt;
    endfunction

    task automatic model_insert(logic [W-1:0] v);
        int idx;
        idx = mq.size();
        for (int k = 0; k < mq.size(); k++) begin
            if (b_first(v, mq[k])) begin
                idx = k;
                break;
            end
        end
        mq.insert(idx, v);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            mphase   = 0;
            mstarted = 1'b0;
            mq.delete();
        end else begin
            case (mphase)
                0: begin
                    if (in_valid) begin
                        if (!mstarted) begin
                            mstarted = 1'b1;
                            msg = m_signed;
                            mds = m_desc;
                        end
                        model_insert(in_data);
                    end
                    if (in_last) begin
                        while (mq.size() > (casc_en ? 2 * D : D)) void'(mq.pop_back());
                        mwait  = casc_en ? 2 * D : D;
                        mphase = 1;
                    end
                end
                1: begin
                    mwait--;
                    if (mwait == 0) mphase = 2;
                end
                default: begin
                    if (mq.size() == 0) begin
                        mphase   = 0;
                        mstarted = 1'b0;
                    end else begin
                        void'(mq.pop_front());
                    end
                end
            endcase
        end
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog: actual hung expected finished", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // Every cycle: compare outputs with the reference.
    always @(negedge clk) begin
        if (chk_en) begin
            bit exp_v;
            exp_v = (mphase == 2) && (mq.size() > 0);
            chk(out_valid == exp_v, "out_valid", 64'(out_valid), 64'(exp_v));
            if (exp_v) chk(out_data == mq[0], "out_data", 64'(out_data), 64'(mq[0]));
        end
    end

    function automatic logic [W-1:0] gen(int pattern);
        if (pattern == 1) return W'($urandom_range(0, 200)) - W'(100);
        if (pattern == 2) return W'($urandom_range(0, 3));
        return W'($urandom);
    endfunction

    task automatic burst(string req, int n, bit gaps, bit sep_last, bit junk,
                         int pattern, bit sg, bit ds, bit flip_mid);
        cur_req  = req;
        m_signed = sg;
        m_desc   = ds;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 2 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_last  = 1'b0;
                in_data  = W'($urandom);
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = gen(pattern);
            in_last  = (i == n - 1) && !sep_last;
            if (flip_mid && i == 1) begin
                m_signed = ~sg;
                m_desc   = ~ds;
            end
        end
        if (sep_last || n == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = W'($urandom);
            in_last  = 1'b1;
        end
        forever begin
            @(negedge clk);
            if (mphase == 0) begin
                in_valid = 1'b0;
                in_last  = 1'b0;
                break;
            end
            if (junk) begin
                in_valid = 1'b1;
                in_data  = W'($urandom);
                in_last  = 1'($urandom_range(0, 1));
                m_signed = 1'($urandom_range(0, 1));
                m_desc   = 1'($urandom_range(0, 1));
            end else begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(posedge clk);
        chk_en = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: empty after reset, nothing passed down
        chk(out_valid == 1'b0, "out_valid after reset", 64'(out_valid), 64'd0);
        chk(cd_valid == 1'b0, "casc_dn_valid after reset", 64'(cd_valid), 64'd0);
        repeat (3) @(negedge clk);

        casc_en = 1'b0;
        burst("R2", D, 0, 0, 1, 0, 0, 0, 0);       // full, back-to-back, unsigned ascending
        burst("R6", 5, 1, 0, 0, 0, 0, 0, 0);       // gaps between records
        burst("R3", 5, 1, 0, 1, 0, 0, 1, 0);       // descending unsigned
        burst("R4", D, 0, 0, 1, 1, 1, 0, 0);       // signed ascending with negatives
        burst("R3", D, 0, 0, 0, 1, 1, 1, 0);       // signed descending
        burst("R2", D, 0, 0, 0, 2, 0, 0, 0);       // many equal keys
        burst("R7", 1, 0, 0, 1, 0, 0, 0, 0);       // single record, end on same cycle
        burst("R7", 3, 0, 0, 0, 1, 1, 0, 0);       // partial fill
        burst("R12", 3, 0, 1, 0, 0, 0, 1, 0);      // separate end marker
        burst("R12", 0, 0, 1, 1, 0, 0, 0, 0);      // empty burst
        burst("R8", D, 0, 0, 0, 1, 1, 0, 1);       // modes flip after first record
        burst("R8", 4, 1, 0, 1, 1, 0, 1, 1);
        burst("R9", 4, 0, 0, 1, 0, 0, 0, 0);       // junk during settle and drain
        burst("R5", D - 1, 0, 0, 1, 0, 0, 1, 0);   // timing and count
        burst("R10", D + 3, 0, 0, 1, 0, 0, 0, 0);  // overflow without cascade
        burst("R10", 2 * D, 1, 0, 0, 1, 1, 1, 0);

        casc_en = 1'b1;
        burst("R11", 2 * D, 0, 0, 1, 0, 0, 0, 0);  // both arrays full
        burst("R11", D + 2, 1, 0, 0, 1, 1, 1, 0);
        burst("R11", D - 2, 0, 0, 1, 1, 1, 0, 0);  // far array stays empty
        burst("R11", 2 * D + 4, 0, 0, 0, 0, 0, 1, 0); // chained overflow
        burst("R11", 0, 0, 1, 0, 0, 0, 0, 0);
        casc_en = 1'b0;
        burst("R5", D, 0, 0, 0, 0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule